// File: doc/BRIEF.md
# Seven-Class Interrupt Priority Selector

This block keeps one pending flag for each of seven interrupt classes and, on every clock, chooses at most one of them to deliver to the core. Producers raise a one-cycle post strobe for their class. The selector then weighs the pending set against the core's state: hypervisor-privilege mode, the global interrupt enable, the trap-level-zero enable together with the current trap level, a 16-bit soft-interrupt register, and a 4-bit interrupt level threshold. It reports the chosen class as a one-cycle take strobe. For soft interrupts, the strobe also carries the level number.

A summary output tells the core that something is pending at all, so the core can skip the full selection when nothing is posted. The fixed priority order depends on the privilege mode. Platform vector interrupts sit between soft-interrupt levels at level 6. A soft interrupt stays pending while other soft level bits remain set, so several levels can be serviced one after another.

Top module: `irq_arbiter`

## Requirements
- R1: A post strobe on bit i of `post_i` sets the pending flag of class i at the next edge. Class codes and bit positions are: 0 trap-level-zero, 1 hypervisor tick match, 2 platform vector, 3 CPU queue, 4 device queue, 5 resumable error, 6 soft interrupt. After the post, `any_pend_o` is high.
- R2: `any_pend_o` is high exactly when the count of pending classes is non-zero. Posting a class that is already pending does not add to that count, so one delivery of that class leaves nothing pending.
- R3: A delivery clears the class's flag and raises `take_o` for one cycle, one cycle after the cycle in which the class was eligible. `take_cls_o` carries the class code. At most one class is delivered per cycle.
- R4: With `hpriv_i` high, only the hypervisor tick match and then the platform vector can be delivered, and only while `ie_i` is high.
- R5: With `hpriv_i` low, trap-level-zero has the highest priority. It is delivered only while `tlz_en_i` is high and `tl_i` is 0.
- R6: With `hpriv_i` low, the hypervisor tick match comes next and is delivered even with `ie_i` low.
- R7: With `hpriv_i` low and `ie_i` high, the remaining classes follow in this order: CPU queue, device queue, soft interrupt, resumable error. With `ie_i` low, none of these is delivered.
- R8: When the soft interrupt is pending, its level is below 6 and a platform vector is pending, the platform vector is delivered instead. This is the only path that delivers a platform vector when `hpriv_i` is low.
- R9: A soft interrupt is delivered only when its level is strictly greater than `pil_i`. `take_lvl_o` then carries that level. For every other class, `take_lvl_o` is 0.
- R10: The soft-interrupt level is the index of the highest set bit among bits 15..1 of `softint_i`. Bit 0 never counts, and the level is 0 when none of bits 15..1 is set.
- R11: After a soft delivery, the soft flag stays set if any bit of 15..1 other than the delivered level is still set. Otherwise the flag clears.
- R12: A post and a delivery of the same class at the same edge leave that class pending.
- R13: After reset no class is pending, and both `any_pend_o` and `take_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_i | input | 7 | One post strobe per class, bit = class code |
| hpriv_i | input | 1 | Hypervisor-privileged mode |
| ie_i | input | 1 | Global interrupt enable |
| tlz_en_i | input | 1 | Trap-level-zero interrupt enable |
| tl_i | input | TL_W (3) | Current trap level |
| softint_i | input | SOFT_W (16) | Soft-interrupt register value |
| pil_i | input | LVL_W (4) | Interrupt level threshold |
| any_pend_o | output | 1 | At least one class pending |
| take_o | output | 1 | One-cycle delivery strobe |
| take_cls_o | output | 3 | Class code of the delivery |
| take_lvl_o | output | LVL_W (4) | Soft level of the delivery, else 0 |

## Verification
A post is captured at the edge that follows it, so `any_pend_o` is due one edge after the strobe. The selection is combinational from the flags, but the take strobe is registered. A delivery therefore shows up one edge after the flags and the status inputs allowed it, which is two edges after the post.

Each vector first posts its classes under a status that blocks every delivery. It then applies the status under test and samples the take outputs at the falling edge after the next rising edge. Checks on persistence and reposting sample `any_pend_o` on that same falling edge, because the flag and the count update at the same edge as the take register.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NCLS  = 7;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_TLZ   = 3'd0,
    CLS_HTICK = 3'd1,
    CLS_VEC   = 3'd2,
    CLS_CPUQ  = 3'd3,
    CLS_DEVQ  = 3'd4,
    CLS_RERR  = 3'd5,
    CLS_SOFT  = 3'd6
  } irq_cls_e;

  // index of the single set bit of a one-hot grant vector
  function automatic logic [CLS_W-1:0] grant_code(logic [NCLS-1:0] oh);
    logic [CLS_W-1:0] c;
    c = '0;
    for (int i = 0; i < NCLS; i++)
      if (oh[i]) c = CLS_W'(i);
    return c;
  endfunction

  function automatic int unsigned pop_cls(logic [NCLS-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < NCLS; i++)
      n += {31'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/irq_soft_enc.sv
module irq_soft_enc #(
  parameter int SOFT_W = 16,
  parameter int LVL_W  = $clog2(SOFT_W)
) (
  input  logic [SOFT_W-1:0] softint_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              rest_nz_o
);
  // highest set bit among SOFT_W-1..1; bit 0 is never a level
  function automatic logic [LVL_W-1:0] top_level(logic [SOFT_W-1:0] si);
    logic [LVL_W-1:0] l;
    l = '0;
    for (int i = 1; i < SOFT_W; i++)
      if (si[i]) l = LVL_W'(i);
    return l;
  endfunction

  // any level bit besides the chosen one still set
  function automatic logic others_left(logic [SOFT_W-1:0] si, logic [LVL_W-1:0] l);
    logic [SOFT_W-1:0] m;
    m = si;
    m[0] = 1'b0;
    m[l] = 1'b0;
    return |m;
  endfunction

  assign lvl_o     = top_level(softint_i);
  assign rest_nz_o = others_left(softint_i, lvl_o);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_arb_pkg::*;
#(
  parameter int N     = NCLS,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] post_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         any_o
);
  logic [N-1:0]     flags_q, flags_n, rise_m, fall_m;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  function automatic logic [CNT_W-1:0] ones(logic [N-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < N; i++)
      n = n + CNT_W'(v[i]);
    return n;
  endfunction

  // a post wins over a clear of the same class
  assign flags_n = post_i | (flags_q & ~clr_i);
  assign rise_m  = flags_n & ~flags_q;
  assign fall_m  = flags_q & ~flags_n;
  assign cnt_n   = cnt_q + ones(rise_m) - ones(fall_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cnt_q   <= '0;
    end else begin
      flags_q <= flags_n;
      cnt_q   <= cnt_n;
    end
  end

  assign flags_o = flags_q;
  assign any_o   = (cnt_q != '0);

  AST_CNT_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'($countones(flags_q))); // R2
  AST_POST_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    |post_i |=> ((flags_q & $past(post_i)) == $past(post_i))); // R12
  AST_CLR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i & ~flags_q) == '0); // R3
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int LVL_W     = 4,
  parameter int VEC_SPLIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   flags_i,
  input  logic              hpriv_i,
  input  logic              ie_i,
  input  logic              tlz_ok_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic              rest_nz_i,
  input  logic [LVL_W-1:0]  pil_i,
  output logic [NCLS-1:0]   grant_o,
  output logic [NCLS-1:0]   clr_o
);
  localparam int I_TLZ  = int'(CLS_TLZ);
  localparam int I_HT   = int'(CLS_HTICK);
  localparam int I_VEC  = int'(CLS_VEC);
  localparam int I_CPU  = int'(CLS_CPUQ);
  localparam int I_DEV  = int'(CLS_DEVQ);
  localparam int I_RERR = int'(CLS_RERR);
  localparam int I_SOFT = int'(CLS_SOFT);
  localparam logic [LVL_W-1:0] SPLIT = LVL_W'(VEC_SPLIT);

  logic soft_low, soft_hi;
  assign soft_low = flags_i[I_SOFT] && (lvl_i < SPLIT) && flags_i[I_VEC];
  assign soft_hi  = flags_i[I_SOFT] && (lvl_i > pil_i);

  always_comb begin
    grant_o = '0;
    if (hpriv_i) begin
      if (ie_i) begin
        if (flags_i[I_HT])       grant_o[I_HT]  = 1'b1;
        else if (flags_i[I_VEC]) grant_o[I_VEC] = 1'b1;
      end
    end else if (flags_i[I_TLZ] && tlz_ok_i) begin
      grant_o[I_TLZ] = 1'b1;
    end else if (flags_i[I_HT]) begin
      grant_o[I_HT] = 1'b1;
    end else if (ie_i) begin
      if (flags_i[I_CPU])       grant_o[I_CPU]  = 1'b1;
      else if (flags_i[I_DEV])  grant_o[I_DEV]  = 1'b1;
      else if (soft_low)        grant_o[I_VEC]  = 1'b1;
      else if (soft_hi)         grant_o[I_SOFT] = 1'b1;
      else if (flags_i[I_RERR]) grant_o[I_RERR] = 1'b1;
    end
  end

  always_comb begin
    clr_o = grant_o;
    clr_o[I_SOFT] = grant_o[I_SOFT] & ~rest_nz_i;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R3
  AST_HPRIV_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hpriv_i |-> (grant_o[I_TLZ] | grant_o[I_CPU] | grant_o[I_DEV] |
                 grant_o[I_RERR] | grant_o[I_SOFT]) == 1'b0); // R4
  AST_SOFT_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[I_SOFT] |-> (lvl_i > pil_i)); // R9
  AST_IE_GATES_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |-> (grant_o[I_CPU] | grant_o[I_DEV] | grant_o[I_RERR] |
               grant_o[I_SOFT] | grant_o[I_VEC]) == 1'b0); // R7
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int TL_W      = 3,
  parameter int SOFT_W    = 16,
  parameter int VEC_SPLIT = 6,
  localparam int LVL_W    = $clog2(SOFT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLS-1:0]   post_i,
  input  logic              hpriv_i,
  input  logic              ie_i,
  input  logic              tlz_en_i,
  input  logic [TL_W-1:0]   tl_i,
  input  logic [SOFT_W-1:0] softint_i,
  input  logic [LVL_W-1:0]  pil_i,
  output logic              any_pend_o,
  output logic              take_o,
  output logic [CLS_W-1:0]  take_cls_o,
  output logic [LVL_W-1:0]  take_lvl_o
);
  logic [NCLS-1:0]  flags, grant, clr;
  logic [LVL_W-1:0] soft_lvl;
  logic             rest_nz, tlz_ok, grant_any;

  assign tlz_ok    = tlz_en_i && (tl_i == '0);
  assign grant_any = |grant;

  irq_soft_enc #(.SOFT_W(SOFT_W), .LVL_W(LVL_W)) u_enc (
    .softint_i (softint_i),
    .lvl_o     (soft_lvl),
    .rest_nz_o (rest_nz)
  );

  irq_pend_bank #(.N(NCLS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .post_i  (post_i),
    .clr_i   (clr),
    .flags_o (flags),
    .any_o   (any_pend_o)
  );

  irq_pick #(.LVL_W(LVL_W), .VEC_SPLIT(VEC_SPLIT)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_i   (flags),
    .hpriv_i   (hpriv_i),
    .ie_i      (ie_i),
    .tlz_ok_i  (tlz_ok),
    .lvl_i     (soft_lvl),
    .rest_nz_i (rest_nz),
    .pil_i     (pil_i),
    .grant_o   (grant),
    .clr_o     (clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      take_cls_o <= '0;
      take_lvl_o <= '0;
    end else begin
      take_o     <= grant_any;
      take_cls_o <= grant_code(grant);
      take_lvl_o <= grant[int'(CLS_SOFT)] ? soft_lvl : '0;
    end
  end

  AST_TAKE_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> take_o); // R3
  AST_TLZ_NEEDS_LEVEL0: assert property (@(posedge clk) disable iff (!rst_n)
    grant[int'(CLS_TLZ)] |-> (tl_i == '0 && tlz_en_i && !hpriv_i)); // R5
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  import irq_arb_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  post = '0;
  logic        hpriv = 1'b1, ie = 1'b0, tlz_en = 1'b0;
  logic [2:0]  tl = '0;
  logic [15:0] softint = '0;
  logic [3:0]  pil = '0;
  logic        any_pend, take;
  logic [2:0]  take_cls;
  logic [3:0]  take_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .post_i(post), .hpriv_i(hpriv), .ie_i(ie),
    .tlz_en_i(tlz_en), .tl_i(tl), .softint_i(softint), .pil_i(pil),
    .any_pend_o(any_pend), .take_o(take), .take_cls_o(take_cls),
    .take_lvl_o(take_lvl)
  );

  typedef struct packed {
    logic [6:0]  post;
    logic        hpriv;
    logic        ie;
    logic        tlz_en;
    logic [2:0]  tl;
    logic [15:0] si;
    logic [3:0]  pil;
    logic        e_take;
    logic [2:0]  e_cls;
    logic [3:0]  e_lvl;
  } vec_t;

  localparam int NV = 15;
  // post bits: 0 tlz,1 htick,2 vec,3 cpu,4 dev,5 rerr,6 soft
  localparam vec_t TBL [NV] = '{
    '{7'b1111000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0200, 4'd3, 1'b1, 3'd3, 4'd0}, // R7 cpu first
    '{7'b1110000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0200, 4'd3, 1'b1, 3'd4, 4'd0}, // R7 dev next
    '{7'b1100000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0200, 4'd3, 1'b1, 3'd6, 4'd9}, // R9 soft lvl 9
    '{7'b1100000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0200, 4'd9, 1'b1, 3'd5, 4'd0}, // R9 not above pil -> rerr
    '{7'b1000100, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0010, 4'd0, 1'b1, 3'd2, 4'd0}, // R8 level 4 -> vector
    '{7'b1000100, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0080, 4'd0, 1'b1, 3'd6, 4'd7}, // R8 level 7 -> soft
    '{7'b0001010, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0000, 4'd0, 1'b1, 3'd1, 4'd0}, // R6 htick w/o ie
    '{7'b0001000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0000, 4'd0, 1'b0, 3'd0, 4'd0}, // R7 no ie -> none
    '{7'b0000011, 1'b0, 1'b0, 1'b1, 3'd0, 16'h0000, 4'd0, 1'b1, 3'd0, 4'd0}, // R5 tlz first
    '{7'b0000011, 1'b0, 1'b0, 1'b1, 3'd2, 16'h0000, 4'd0, 1'b1, 3'd1, 4'd0}, // R5 tl!=0 -> htick
    '{7'b0001100, 1'b1, 1'b1, 1'b0, 3'd0, 16'h0000, 4'd0, 1'b1, 3'd2, 4'd0}, // R4 hpriv vector
    '{7'b0000110, 1'b1, 1'b1, 1'b0, 3'd0, 16'h0000, 4'd0, 1'b1, 3'd1, 4'd0}, // R4 hpriv htick first
    '{7'b0000110, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0000, 4'd0, 1'b0, 3'd0, 4'd0}, // R4 hpriv no ie
    '{7'b1000000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0001, 4'd0, 1'b0, 3'd0, 4'd0}, // R10 bit0 ignored
    '{7'b1000000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h8003, 4'd14, 1'b1, 3'd6, 4'd15} // R10 top bit wins
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold_status();
    hpriv = 1'b1; ie = 1'b0; tlz_en = 1'b0; tl = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; post = '0; hold_status();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    // R13 reset state
    do_reset();
    chk("R13 any_pend", int'(any_pend), 0);
    chk("R13 take", int'(take), 0);

    // table walk: post under a blocking status, then apply the status under test
    for (int k = 0; k < NV; k++) begin
      do_reset();
      softint = TBL[k].si; pil = TBL[k].pil; tl = TBL[k].tl;
      post = TBL[k].post;
      @(negedge clk);
      post = '0;
      chk("R1 any_pend after post", int'(any_pend), 1);
      hpriv = TBL[k].hpriv; ie = TBL[k].ie; tlz_en = TBL[k].tlz_en;
      @(negedge clk);
      chk($sformatf("vec%0d take", k), int'(take), int'(TBL[k].e_take));
      if (TBL[k].e_take) begin
        chk($sformatf("vec%0d R3 class", k), int'(take_cls), int'(TBL[k].e_cls));
        chk($sformatf("vec%0d R9 level", k), int'(take_lvl), int'(TBL[k].e_lvl));
      end
    end

    // R2: double post counted once; R3: single-cycle take
    do_reset();
    post = 7'b0001000;
    @(negedge clk);
    @(negedge clk);
    post = '0;
    hpriv = 1'b0; ie = 1'b1;
    @(negedge clk);
    chk("R3 take cpu", int'(take), 1);
    chk("R3 cls cpu", int'(take_cls), 3);
    chk("R2 nothing left after one delivery", int'(any_pend), 0);
    @(negedge clk);
    chk("R3 take one cycle", int'(take), 0);

    // R11: soft flag persists while other level bits remain
    do_reset();
    softint = 16'h0220; pil = 4'd0;
    post = 7'b1000000;
    @(negedge clk);
    post = '0; hpriv = 1'b0; ie = 1'b1;
    @(negedge clk);
    chk("R11 first soft take", int'(take), 1);
    chk("R11 first soft lvl", int'(take_lvl), 9);
    chk("R11 still pending", int'(any_pend), 1);
    softint = 16'h0200;
    @(negedge clk);
    chk("R11 second soft take", int'(take), 1);
    chk("R11 second soft lvl", int'(take_lvl), 9);
    chk("R11 cleared when last level", int'(any_pend), 0);

    // R12: post and delivery of the same class at one edge
    do_reset();
    post = 7'b0001000;
    @(negedge clk);
    hpriv = 1'b0; ie = 1'b1; post = 7'b0001000;
    @(negedge clk);
    post = '0;
    chk("R12 take cpu", int'(take), 1);
    chk("R12 still pending", int'(any_pend), 1);
    @(negedge clk);
    chk("R12 second take", int'(take), 1);
    chk("R12 then empty", int'(any_pend), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule